// File: doc/BRIEF.md
# Round-Robin Warp Scheduler

This block selects at most one warp per clock cycle to hand to the instruction fetch stage of a multi-warp core. It keeps three pieces of state: a mask of active warps, a mask of warps locked out of selection, and the index of the most recently selected warp. Each cycle it scans the warps in a rotating order that starts just after the last selected warp. It picks the first warp that is active and not locked out, and reports that warp with a registered valid strobe, a warp index and a unique instruction sequence number.

A selected warp stays locked out until the decode stage sends a release for it. As a result, each warp has at most one instruction in the front end at a time. Decode can hold the lockout by flagging the instruction as a fetch stall. Other units can activate or suspend single warps. A spawn request enables warps 1 and up together and publishes the start PC for them. Per-warp program counters, fetch and decode sit outside this block.

Top module: `warp_sched`

## Requirements
- R1: While rst_ni is low, active_o is 1 (only warp 0), stalled_o is 0, issue_valid_o is 0, spawn_mask_o is 0, and the last-selected index is 0. As a result, the first selection after reset is warp 0 with sequence number CORE_ID.
- R2: A warp is a candidate only when its active bit is 1 and its stall bit is 0. When no warp is a candidate, issue_valid_o is 0 in the next cycle and the last-selected index does not change.
- R3: The scan starts at the warp after the last selected one and wraps modulo NUM_WARPS, visiting every warp once. The first candidate found is selected.
- R4: The selection is registered. issue_valid_o and issue_wid_o appear on the clock edge that follows the cycle in which the state was seen. On that same edge the selected warp's bit in stalled_o becomes 1 and the last-selected index becomes that warp.
- R5: A release (release_valid_i with release_hold_i low) clears bit release_wid_i of stalled_o at the next edge. A release with release_hold_i high changes nothing.
- R6: When a release and a selection fall in the same cycle, the release is applied first. A warp released in a cycle can therefore be selected in that same cycle.
- R7: A spawn request with count N sets active bits 1 through min(N, NUM_WARPS)-1. It also loads spawn_mask_o with those bits plus bit 0, and loads spawn_pc_o with spawn_pc_i. N of 0 or 1 gives spawn_mask_o = 1 and activates nothing.
- R8: act_valid_i sets bit act_wid_i of active_o, and susp_valid_i clears bit susp_wid_i. If both name the same warp in one cycle, the suspend wins. Changes to the active mask take effect for selection from the next cycle on.
- R9: The k-th selection after reset (k from 0) carries issue_uid_o = k*CORE_COUNT + CORE_ID. Cycles without a selection do not advance k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| release_valid_i | input | 1 | Decode release request |
| release_wid_i | input | WID_W | Warp to release |
| release_hold_i | input | 1 | Fetch-stall flag: keep the warp locked |
| spawn_valid_i | input | 1 | Spawn request |
| spawn_cnt_i | input | CNT_W | Requested number of warps, counting warp 0 |
| spawn_pc_i | input | PC_W | Start PC for spawned warps |
| act_valid_i | input | 1 | Activate request |
| act_wid_i | input | WID_W | Warp to activate |
| susp_valid_i | input | 1 | Suspend request |
| susp_wid_i | input | WID_W | Warp to suspend |
| issue_valid_o | output | 1 | A warp was selected |
| issue_wid_o | output | WID_W | Selected warp |
| issue_uid_o | output | UID_W | Sequence number of the selection |
| active_o | output | NUM_WARPS | Active-warp mask |
| stalled_o | output | NUM_WARPS | Locked-out warp mask |
| spawn_mask_o | output | NUM_WARPS | Mask returned by the last spawn |
| spawn_pc_o | output | PC_W | PC of the last spawn |

## Verification
The hardest case to reach is a release and a selection landing on the same warp in the same cycle while that warp is the only one that could be chosen. Random traffic rarely produces it, because other active warps usually win the scan. Directed steps therefore reduce the core to warp 0 alone and release it in the cycle right after it is picked, so it must be picked again. Long random runs that spread activates, suspends, held and plain releases, and clamped spawns cover the wrap-around order of the scan against a bench model.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  function automatic int unsigned wrap_add(int unsigned base, int unsigned step, int unsigned modulus);
    return (base + step) % modulus;
  endfunction
endpackage

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
  parameter int NUM_WARPS = 8,
  localparam int WID_W = $clog2(NUM_WARPS)
) (
  input  logic [NUM_WARPS-1:0] elig_i,
  input  logic [WID_W-1:0]     last_i,
  output logic                 found_o,
  output logic [WID_W-1:0]     pick_o
);
  import warp_sched_pkg::*;
  int unsigned idx;
  always_comb begin
    found_o = 1'b0;
    pick_o  = last_i;
    idx     = 0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      idx = wrap_add(int'(last_i), k, NUM_WARPS);
      if (!found_o && elig_i[idx]) begin
        found_o = 1'b1;
        pick_o  = WID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/warp_spawn_mask.sv
module warp_spawn_mask #(
  parameter int NUM_WARPS = 8,
  parameter int CNT_W     = 8
) (
  input  logic [CNT_W-1:0]     cnt_i,
  output logic [NUM_WARPS-1:0] new_o
);
  // bits 1..min(N,W)-1; the bound i < NUM_WARPS clamps by construction
  always_comb begin
    new_o = '0;
    for (int i = 1; i < NUM_WARPS; i++) new_o[i] = (i < int'(cnt_i));
  end
endmodule

// File: rtl/warp_uid_gen.sv
module warp_uid_gen #(
  parameter int UID_W      = 32,
  parameter int CORE_COUNT = 4,
  parameter int CORE_ID    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  output logic [UID_W-1:0] uid_o
);
  logic [UID_W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      uid_o <= '0;
    end else if (fire_i) begin
      uid_o <= UID_W'(cnt_q * UID_W'(CORE_COUNT) + UID_W'(CORE_ID));
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/warp_sched.sv
module warp_sched #(
  parameter int NUM_WARPS  = 8,
  parameter int CNT_W      = 8,
  parameter int PC_W       = 32,
  parameter int UID_W      = 32,
  parameter int CORE_COUNT = 4,
  parameter int CORE_ID    = 2,
  localparam int WID_W     = $clog2(NUM_WARPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 release_valid_i,
  input  logic [WID_W-1:0]     release_wid_i,
  input  logic                 release_hold_i,
  input  logic                 spawn_valid_i,
  input  logic [CNT_W-1:0]     spawn_cnt_i,
  input  logic [PC_W-1:0]      spawn_pc_i,
  input  logic                 act_valid_i,
  input  logic [WID_W-1:0]     act_wid_i,
  input  logic                 susp_valid_i,
  input  logic [WID_W-1:0]     susp_wid_i,
  output logic                 issue_valid_o,
  output logic [WID_W-1:0]     issue_wid_o,
  output logic [UID_W-1:0]     issue_uid_o,
  output logic [NUM_WARPS-1:0] active_o,
  output logic [NUM_WARPS-1:0] stalled_o,
  output logic [NUM_WARPS-1:0] spawn_mask_o,
  output logic [PC_W-1:0]      spawn_pc_o
);
  logic [NUM_WARPS-1:0] active_q, stalled_q, rel_mask, stall_rel, elig;
  logic [NUM_WARPS-1:0] spawn_new, act_mask, susp_mask, pick_mask;
  logic [WID_W-1:0]     last_q, pick;
  logic                 found;

  always_comb begin
    rel_mask  = '0;
    act_mask  = '0;
    susp_mask = '0;
    pick_mask = '0;
    if (release_valid_i && !release_hold_i) rel_mask[release_wid_i] = 1'b1;
    if (act_valid_i)  act_mask[act_wid_i]   = 1'b1;
    if (susp_valid_i) susp_mask[susp_wid_i] = 1'b1;
    if (found)        pick_mask[pick]       = 1'b1;
  end

  // release lands before the scan
  assign stall_rel = stalled_q & ~rel_mask;
  assign elig      = active_q & ~stall_rel;

  warp_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
    .elig_i(elig), .last_i(last_q), .found_o(found), .pick_o(pick)
  );

  warp_spawn_mask #(.NUM_WARPS(NUM_WARPS), .CNT_W(CNT_W)) u_spawn (
    .cnt_i(spawn_cnt_i), .new_o(spawn_new)
  );

  warp_uid_gen #(.UID_W(UID_W), .CORE_COUNT(CORE_COUNT), .CORE_ID(CORE_ID)) u_uid (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(found), .uid_o(issue_uid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q      <= NUM_WARPS'(1);
      stalled_q     <= '0;
      last_q        <= '0;
      issue_valid_o <= 1'b0;
      issue_wid_o   <= '0;
      spawn_mask_o  <= '0;
      spawn_pc_o    <= '0;
    end else begin
      stalled_q     <= stall_rel | pick_mask;
      active_q      <= (active_q | act_mask | (spawn_valid_i ? spawn_new : '0)) & ~susp_mask;
      issue_valid_o <= found;
      if (found) begin
        last_q      <= pick;
        issue_wid_o <= pick;
      end
      if (spawn_valid_i) begin
        spawn_mask_o <= spawn_new | NUM_WARPS'(1);
        spawn_pc_o   <= spawn_pc_i;
      end
    end
  end

  assign active_o  = active_q;
  assign stalled_o = stalled_q;
endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk #(
  parameter int NUM_WARPS  = 8,
  parameter int UID_W      = 32,
  parameter int CORE_COUNT = 4,
  parameter int CORE_ID    = 2,
  localparam int WID_W     = $clog2(NUM_WARPS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 issue_valid_o,
  input logic [WID_W-1:0]     issue_wid_o,
  input logic [UID_W-1:0]     issue_uid_o,
  input logic [NUM_WARPS-1:0] active_o,
  input logic [NUM_WARPS-1:0] stalled_o,
  input logic [NUM_WARPS-1:0] spawn_mask_o
);
  logic [NUM_WARPS-1:0] prev_active;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_active <= NUM_WARPS'(1);
    else         prev_active <= active_o;
  end

  p_pick_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> stalled_o[issue_wid_o]);
  p_pick_was_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> prev_active[issue_wid_o]);
  p_no_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(active_o & ~stalled_o)) |=> issue_valid_o);
  p_spawn_self_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|spawn_mask_o) |-> spawn_mask_o[0]);
  p_uid_core_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> ((issue_uid_o % UID_W'(CORE_COUNT)) == UID_W'(CORE_ID)));
endmodule

bind warp_sched warp_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .UID_W(UID_W), .CORE_COUNT(CORE_COUNT), .CORE_ID(CORE_ID)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .issue_valid_o(issue_valid_o),
  .issue_wid_o(issue_wid_o), .issue_uid_o(issue_uid_o), .active_o(active_o),
  .stalled_o(stalled_o), .spawn_mask_o(spawn_mask_o)
);

// File: tb/warp_sched_bench.sv
module warp_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int WW = 3;
  localparam int CC = 4;
  localparam int CID = 2;

  logic clk = 0, rst_ni = 0;
  logic rel_v = 0, rel_h = 0, sp_v = 0, act_v = 0, sus_v = 0;
  logic [WW-1:0] rel_w = 0, act_w = 0, sus_w = 0;
  logic [7:0] sp_cnt = 0;
  logic [31:0] sp_pc = 0;
  logic iv;
  logic [WW-1:0] iw;
  logic [31:0] iu, spc;
  logic [NW-1:0] act, stl, smask;

  int n_checks = 0, n_fail = 0;
  logic [NW-1:0] m_act, m_stl, e_smask;
  int m_last, m_cnt;
  logic e_v;
  int e_w, e_u;
  logic [31:0] e_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_sched u_warp_sched (
    .clk_i(clk), .rst_ni(rst_ni),
    .release_valid_i(rel_v), .release_wid_i(rel_w), .release_hold_i(rel_h),
    .spawn_valid_i(sp_v), .spawn_cnt_i(sp_cnt), .spawn_pc_i(sp_pc),
    .act_valid_i(act_v), .act_wid_i(act_w), .susp_valid_i(sus_v), .susp_wid_i(sus_w),
    .issue_valid_o(iv), .issue_wid_o(iw), .issue_uid_o(iu),
    .active_o(act), .stalled_o(stl), .spawn_mask_o(smask), .spawn_pc_o(spc)
  );

  task automatic chk(string req, longint actual, longint expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, actual, expected, $time);
    end
  endtask

  function automatic logic [NW-1:0] spawn_bits(int n);
    logic [NW-1:0] b = '0;
    for (int i = 1; i < NW; i++) if (i < n) b[i] = 1'b1;
    return b;
  endfunction

  // reference step from the requirements, using inputs of this cycle
  task automatic model_step();
    logic [NW-1:0] rel = '0, sr, el, nxt_act;
    bit found = 0;
    int p = 0;
    if (rel_v && !rel_h) rel[rel_w] = 1'b1;
    sr = m_stl & ~rel;
    el = m_act & ~sr;
    for (int k = 1; k <= NW; k++) begin
      int idx = (m_last + k) % NW;
      if (!found && el[idx]) begin found = 1; p = idx; end
    end
    nxt_act = m_act;
    if (sp_v) nxt_act |= spawn_bits(int'(sp_cnt));
    if (act_v) nxt_act[act_w] = 1'b1;
    if (sus_v) nxt_act[sus_w] = 1'b0;
    if (sp_v) begin e_smask = spawn_bits(int'(sp_cnt)) | 1; e_pc = sp_pc; end
    e_v = found;
    if (found) begin
      sr[p] = 1'b1; m_last = p; e_w = p;
      e_u = m_cnt * CC + CID; m_cnt++;
    end
    m_stl = sr;
    m_act = nxt_act;
  endtask

  task automatic step_and_check(string tag);
    model_step();
    @(posedge clk); #1;
    chk({tag, " R4 valid"}, iv, e_v);
    if (e_v) begin
      chk({tag, " R3 wid"}, iw, e_w);
      chk({tag, " R9 uid"}, iu, e_u);
    end
    chk({tag, " R8 active"}, act, m_act);
    chk({tag, " R5 stalled"}, stl, m_stl);
    chk({tag, " R7 spawn_mask"}, smask, e_smask);
    chk({tag, " R7 spawn_pc"}, spc, e_pc);
    @(negedge clk);
    rel_v = 0; rel_h = 0; sp_v = 0; act_v = 0; sus_v = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    m_act = 1; m_stl = 0; m_last = 0; m_cnt = 0; e_smask = 0; e_pc = 0;
    #(CLK_PERIOD * 3);
    chk("R1 reset active", act, 1);
    chk("R1 reset stalled", stl, 0);
    chk("R1 reset valid", iv, 0);
    chk("R1 reset spawn_mask", smask, 0);
    @(negedge clk); rst_ni = 1;
    // R1 first pick is warp 0; R2 then nothing eligible
    step_and_check("R1 first");
    step_and_check("R2 idle");
    // R6: release warp 0 in the cycle it would be picked again
    rel_v = 1; rel_w = 0; step_and_check("R6 rel+pick");
    rel_v = 1; rel_w = 0; rel_h = 1; step_and_check("R5 hold");
    step_and_check("R5 still locked");
    // R7 spawn clamp and small counts
    sp_v = 1; sp_cnt = 1; sp_pc = 32'h100; step_and_check("R7 n1");
    sp_v = 1; sp_cnt = 0; sp_pc = 32'h104; step_and_check("R7 n0");
    sp_v = 1; sp_cnt = 20; sp_pc = 32'h200; step_and_check("R7 clamp");
    // R8 activate and suspend same warp
    act_v = 1; act_w = 3; sus_v = 1; sus_w = 3; step_and_check("R8 both");
    for (int i = 0; i < 12; i++) begin
      rel_v = 1; rel_w = WW'(i % NW); step_and_check("R3 rotate");
    end
    sp_v = 1; sp_cnt = 5; sp_pc = 32'h300; step_and_check("R7 n5");
    for (int i = 0; i < 1500; i++) begin
      rel_v = ($urandom % 4) != 0; rel_w = WW'($urandom); rel_h = ($urandom % 5) == 0;
      act_v = ($urandom % 8) == 0; act_w = WW'($urandom);
      sus_v = ($urandom % 10) == 0; sus_w = WW'($urandom);
      sp_v = ($urandom % 40) == 0; sp_cnt = 8'($urandom % 12); sp_pc = $urandom;
      step_and_check("rand");
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule